// File: doc/BRIEF.md
# Flash Access Control Register

This block is the bus-visible control word that sets how an embedded flash array is read. It holds a 4-bit wait-state count, a prefetch enable, a low-power read select, a power-down request and a sleep power-down select. It drives these values as level outputs to the flash controller. Every access carries two attributes: whether it is secure and whether it is privileged. Two attribute inputs mark groups of fields as secure. Two protection inputs decide whether unprivileged writes are refused. A field that is secure and is reached by a non-secure access reads as zero, and writes to it are dropped without raising any error.

A second register word, the power-down key, guards the power-down request. Software opens it by writing two fixed 32-bit words in a row. After that it may set the request. When the flash acknowledges entry into power-down, the block clears the request and closes the key again. Writes that would change the low-power read select or the power-down request are refused while a program or erase is in progress. The low-power read select is also refused while the write buffer still holds data.

Top module: `flash_access_ctrl`

## Requirements
- R1: After reset every field is zero and the key is locked. A read of the control word returns 0x0000_0000.
- R2: Field positions in the control word (regSel=0) are: wait states in [3:0], prefetch enable in bit 8, low-power read in bit 11, power-down request in bit 12, sleep power-down in bit 14. A secure privileged write updates the fields it is allowed to change, and the following read returns them.
- R3: When clkSecAttr=1 the wait-state field is secure. When lpSecAttr=1 the low-power read, power-down request and sleep power-down fields are secure. A non-secure access (accSecure=0) reads such a field as zero and cannot change it. The other fields are unaffected, and no error of any kind is produced.
- R4: An unprivileged write (accPriv=0) to a field is dropped when that field is protected. A secure field is protected by secPrivProt. A non-secure field is protected by nsPrivProt. The prefetch enable is always non-secure, so only nsPrivProt protects it.
- R5: A write to the low-power read bit is refused, and the bit keeps its value, while flashBusy=1 or wbufPending=1.
- R6: The power-down request can be written only while the key is open. The key (regSel=1) opens after 32'h5A3C_96E1 and then 32'hA5C3_691E are written back to back. Once the key is open, any further key write leaves it open.
- R7: A wrong word written to the key while it is still locked keeps it locked until reset, even if the correct pair follows.
- R8: A pulse on pdAck clears the power-down request and locks the key again. If pdAck arrives in the same cycle as a write that sets the request, pdAck wins.
- R9: A write to the power-down request is refused while flashBusy=1.
- R10: rdValid is high in the cycle after rdEn, and rdData holds the word in that cycle. Bits not assigned to a field read as zero, and a read of the key word returns zero.
- R11: The outputs latency, prefetchEn, lowPowerRd, pdRequest and sleepPd always equal the stored field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| regSel | input | 1 | 0 selects the control word, 1 selects the key word |
| wrData | input | 32 | Write data |
| accSecure | input | 1 | Access is secure |
| accPriv | input | 1 | Access is privileged |
| clkSecAttr | input | 1 | Marks the wait-state field secure |
| lpSecAttr | input | 1 | Marks the low-power fields secure |
| secPrivProt | input | 1 | Secure fields refuse unprivileged writes |
| nsPrivProt | input | 1 | Non-secure fields refuse unprivileged writes |
| flashBusy | input | 1 | Program or erase in progress |
| wbufPending | input | 1 | Write buffer not empty |
| pdAck | input | 1 | Flash has entered power-down (pulse) |
| rdData | output | 32 | Read data |
| rdValid | output | 1 | Read data valid |
| latency | output | 4 | Wait-state count |
| prefetchEn | output | 1 | Prefetch enable |
| lowPowerRd | output | 1 | Low-power read mode |
| pdRequest | output | 1 | Power-down request level |
| sleepPd | output | 1 | Power-down during sleep |

## Verification
The power-down acknowledge and a software write that sets the power-down request can land in the same clock. The bench opens the key and then issues a control write with bit 12 set while pdAck is held high for that same cycle. The outcome is judged from the outputs. pdRequest must stay low in the following cycle, and a later write of bit 12 without a new key sequence must also leave it low. This shows that the acknowledge won and that it closed the key.

// File: rtl/flash_acc_pkg.sv
package flash_acc_pkg;
  localparam int DATA_W  = 32;
  localparam int LAT_W   = 4;
  localparam int LAT_LSB = 0;
  localparam int PFE_BIT = 8;
  localparam int LPM_BIT = 11;
  localparam int PDR_BIT = 12;
  localparam int SLP_BIT = 14;
  localparam logic [DATA_W-1:0] KEY_WORD_A = 32'h5A3C_96E1;
  localparam logic [DATA_W-1:0] KEY_WORD_B = 32'hA5C3_691E;

  typedef enum logic [1:0] {KEY_WAIT_A, KEY_WAIT_B, KEY_OPEN, KEY_DEAD} keyState_t;

  typedef struct packed {
    logic wrLat;
    logic wrPfe;
    logic wrLpm;
    logic wrPdr;
    logic wrSlp;
    logic clrPdr;
    logic rdStb;
    logic showLat;
    logic showPfe;
    logic showLp;
  } ctrlStb_t;
endpackage

// File: rtl/flash_acc_ctrl.sv
module flash_acc_ctrl
  import flash_acc_pkg::*;
#(
  parameter int DATA_W = flash_acc_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              accSecure,
  input  logic              accPriv,
  input  logic              clkSecAttr,
  input  logic              lpSecAttr,
  input  logic              secPrivProt,
  input  logic              nsPrivProt,
  input  logic              flashBusy,
  input  logic              wbufPending,
  input  logic              pdAck,
  output ctrlStb_t          stb
);
  keyState_t keyState, keyNext;
  logic ctrlWr, keyWr;
  logic latVis, lpVis;
  logic latOk, pfeOk, lpOk;

  // A field is reachable when the access is secure or the field is not secure.
  // A write also needs privilege when the protection input for the field's
  // security domain is set.
  function automatic logic fieldWritable(input logic fieldSec, input logic isSec,
                                         input logic isPriv, input logic sProt,
                                         input logic nsProt);
    logic vis, prot;
    vis  = isSec || !fieldSec;
    prot = fieldSec ? sProt : nsProt;
    return vis && (isPriv || !prot);
  endfunction

  assign ctrlWr = wrEn && !regSel;
  assign keyWr  = wrEn && regSel;
  assign latVis = accSecure || !clkSecAttr;
  assign lpVis  = accSecure || !lpSecAttr;
  assign latOk  = fieldWritable(clkSecAttr, accSecure, accPriv, secPrivProt, nsPrivProt);
  assign lpOk   = fieldWritable(lpSecAttr, accSecure, accPriv, secPrivProt, nsPrivProt);
  assign pfeOk  = fieldWritable(1'b0, accSecure, accPriv, secPrivProt, nsPrivProt);

  always_comb begin
    keyNext = keyState;
    if (pdAck) begin
      if (keyState != KEY_DEAD) keyNext = KEY_WAIT_A;
    end else if (keyWr) begin
      unique case (keyState)
        KEY_WAIT_A: keyNext = (wrData == KEY_WORD_A) ? KEY_WAIT_B : KEY_DEAD;
        KEY_WAIT_B: keyNext = (wrData == KEY_WORD_B) ? KEY_OPEN : KEY_DEAD;
        KEY_OPEN:   keyNext = KEY_OPEN;
        KEY_DEAD:   keyNext = KEY_DEAD;
        default:    keyNext = KEY_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) keyState <= KEY_WAIT_A;
    else       keyState <= keyNext;
  end

  always_comb begin
    stb         = '0;
    stb.wrLat   = ctrlWr && latOk;
    stb.wrPfe   = ctrlWr && pfeOk;
    stb.wrLpm   = ctrlWr && lpOk && !flashBusy && !wbufPending;
    stb.wrPdr   = ctrlWr && lpOk && !flashBusy && !pdAck && (keyState == KEY_OPEN);
    stb.wrSlp   = ctrlWr && lpOk;
    stb.clrPdr  = pdAck;
    stb.rdStb   = rdEn;
    stb.showLat = rdEn && !regSel && latVis;
    stb.showPfe = rdEn && !regSel;
    stb.showLp  = rdEn && !regSel && lpVis;
  end
endmodule

// File: rtl/flash_acc_dp.sv
module flash_acc_dp
  import flash_acc_pkg::*;
#(
  parameter int DATA_W = flash_acc_pkg::DATA_W,
  parameter int LAT_W  = flash_acc_pkg::LAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [LAT_W-1:0]  latency,
  output logic              prefetchEn,
  output logic              lowPowerRd,
  output logic              pdRequest,
  output logic              sleepPd
);
  logic [DATA_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latency    <= '0;
      prefetchEn <= 1'b0;
      lowPowerRd <= 1'b0;
      sleepPd    <= 1'b0;
      pdRequest  <= 1'b0;
    end else begin
      if (stb.wrLat) latency    <= wrData[LAT_LSB +: LAT_W];
      if (stb.wrPfe) prefetchEn <= wrData[PFE_BIT];
      if (stb.wrLpm) lowPowerRd <= wrData[LPM_BIT];
      if (stb.wrSlp) sleepPd    <= wrData[SLP_BIT];
      if (stb.clrPdr)     pdRequest <= 1'b0;
      else if (stb.wrPdr) pdRequest <= wrData[PDR_BIT];
    end
  end

  always_comb begin
    rdWord = '0;
    if (stb.showLat) rdWord[LAT_LSB +: LAT_W] = latency;
    if (stb.showPfe) rdWord[PFE_BIT] = prefetchEn;
    if (stb.showLp) begin
      rdWord[LPM_BIT] = lowPowerRd;
      rdWord[PDR_BIT] = pdRequest;
      rdWord[SLP_BIT] = sleepPd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdStb;
      if (stb.rdStb) rdData <= rdWord;
    end
  end
endmodule

// File: rtl/flash_access_ctrl.sv
module flash_access_ctrl
  import flash_acc_pkg::*;
#(
  parameter int DATA_W = flash_acc_pkg::DATA_W,
  parameter int LAT_W  = flash_acc_pkg::LAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              accSecure,
  input  logic              accPriv,
  input  logic              clkSecAttr,
  input  logic              lpSecAttr,
  input  logic              secPrivProt,
  input  logic              nsPrivProt,
  input  logic              flashBusy,
  input  logic              wbufPending,
  input  logic              pdAck,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [LAT_W-1:0]  latency,
  output logic              prefetchEn,
  output logic              lowPowerRd,
  output logic              pdRequest,
  output logic              sleepPd
);
  ctrlStb_t stb;

  flash_acc_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .accSecure(accSecure), .accPriv(accPriv),
    .clkSecAttr(clkSecAttr), .lpSecAttr(lpSecAttr),
    .secPrivProt(secPrivProt), .nsPrivProt(nsPrivProt),
    .flashBusy(flashBusy), .wbufPending(wbufPending), .pdAck(pdAck),
    .stb(stb)
  );

  flash_acc_dp #(.DATA_W(DATA_W), .LAT_W(LAT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .latency(latency),
    .prefetchEn(prefetchEn), .lowPowerRd(lowPowerRd),
    .pdRequest(pdRequest), .sleepPd(sleepPd)
  );
endmodule

// File: rtl/flash_access_ctrl_chk.sv
module flash_access_ctrl_chk
  import flash_acc_pkg::*;
#(
  parameter int DATA_W = flash_acc_pkg::DATA_W,
  parameter int LAT_W  = flash_acc_pkg::LAT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              accSecure,
  input logic              clkSecAttr,
  input logic              flashBusy,
  input logic              wbufPending,
  input logic              pdAck,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic [LAT_W-1:0]  latency,
  input logic              lowPowerRd,
  input logic              pdRequest
);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'(((1 << LAT_W) - 1) << LAT_LSB) | (DATA_W'(1) << PFE_BIT) |
    (DATA_W'(1) << LPM_BIT) | (DATA_W'(1) << PDR_BIT) | (DATA_W'(1) << SLP_BIT);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    pdAck |=> !pdRequest);

  a_r9_no_request_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    flashBusy |=> !$rose(pdRequest));

  a_r5_lpm_held: assert property (@(posedge clk) disable iff (!rstN)
    (flashBusy || wbufPending) |=> $stable(lowPowerRd));

  a_r3_ns_latency_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !accSecure && clkSecAttr) |=> $stable(latency));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ((rdData & ~USED_MASK) == '0));
endmodule

bind flash_access_ctrl flash_access_ctrl_chk #(.DATA_W(DATA_W), .LAT_W(LAT_W)) uChk (.*);

// File: tb/sim_flash_access_ctrl.sv
module sim_flash_access_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] KA = 32'h5A3C_96E1;
  localparam logic [31:0] KB = 32'hA5C3_691E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, regSel = 1'b0;
  logic [31:0] wrData = '0;
  logic accSecure = 1'b1, accPriv = 1'b1;
  logic clkSecAttr = 1'b0, lpSecAttr = 1'b0, secPrivProt = 1'b0, nsPrivProt = 1'b0;
  logic flashBusy = 1'b0, wbufPending = 1'b0, pdAck = 1'b0;
  logic [31:0] rdData;
  logic rdValid;
  logic [3:0] latency;
  logic prefetchEn, lowPowerRd, pdRequest, sleepPd;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_access_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .accSecure(accSecure), .accPriv(accPriv),
    .clkSecAttr(clkSecAttr), .lpSecAttr(lpSecAttr),
    .secPrivProt(secPrivProt), .nsPrivProt(nsPrivProt),
    .flashBusy(flashBusy), .wbufPending(wbufPending), .pdAck(pdAck),
    .rdData(rdData), .rdValid(rdValid), .latency(latency),
    .prefetchEn(prefetchEn), .lowPowerRd(lowPowerRd),
    .pdRequest(pdRequest), .sleepPd(sleepPd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, input logic ack = 1'b0);
    @(negedge clk);
    regSel = sel; wrData = d; wrEn = 1'b1; pdAck = ack;
    @(negedge clk);
    wrEn = 1'b0; pdAck = 1'b0; wrData = '0;
  endtask

  task automatic openKey();
    wr(1'b1, KA);
    wr(1'b1, KB);
  endtask

  // driver: pushes the expected word, the monitor compares when rdValid shows
  task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    regSel = sel; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected rdValid actual=%h expected=none", rdData);
      end else begin
        chk(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 outputs", {latency, prefetchEn, lowPowerRd, pdRequest, sleepPd}, '0);
    rd(1'b0, 32'h0, "R1 reset word");
    // R2 placement; R6 pdr ignored while key locked
    wr(1'b0, 32'h0000_5905);
    rd(1'b0, 32'h0000_4905, "R2 fields R6 locked");
    chk("R11 latency out", latency, 32'h5);
    chk("R11 flags out", {prefetchEn, lowPowerRd, pdRequest, sleepPd}, 4'b1101);
    // R3 non-secure access to secure fields
    clkSecAttr = 1'b1; lpSecAttr = 1'b1; accSecure = 1'b0;
    rd(1'b0, 32'h0000_0100, "R3 ns read RAZ");
    wr(1'b0, 32'h0000_0000);
    accSecure = 1'b1;
    rd(1'b0, 32'h0000_4805, "R3 ns write ignored");
    // R4 privilege rules
    accPriv = 1'b0; secPrivProt = 1'b1; nsPrivProt = 1'b0;
    wr(1'b0, 32'h0000_0100);
    rd(1'b0, 32'h0000_4905, "R4 secure prot blocks, pfe allowed");
    clkSecAttr = 1'b0; secPrivProt = 1'b0; nsPrivProt = 1'b1;
    wr(1'b0, 32'h0000_0009);
    rd(1'b0, 32'h0000_0105, "R4 ns prot blocks lat and pfe");
    accPriv = 1'b1; lpSecAttr = 1'b0; nsPrivProt = 1'b0;
    // R5 lpm refused while busy or buffer pending
    flashBusy = 1'b1;
    wr(1'b0, 32'h0000_0905);
    flashBusy = 1'b0;
    rd(1'b0, 32'h0000_0105, "R5 busy");
    wbufPending = 1'b1;
    wr(1'b0, 32'h0000_0905);
    wbufPending = 1'b0;
    rd(1'b0, 32'h0000_0105, "R5 wbuf");
    wr(1'b0, 32'h0000_0905);
    chk("R5 lpm accepted", lowPowerRd, 1'b1);
    // R6 key opens; R9 busy refuses pdr
    openKey();
    wr(1'b1, 32'hDEAD_BEEF);
    flashBusy = 1'b1;
    wr(1'b0, 32'h0000_1905);
    flashBusy = 1'b0;
    chk("R9 pdr refused while busy", pdRequest, 1'b0);
    wr(1'b0, 32'h0000_1905);
    chk("R6 pdr set with key open", pdRequest, 1'b1);
    rd(1'b0, 32'h0000_1905, "R6 read pdr");
    rd(1'b1, 32'h0, "R10 key word reads zero");
    // R8 ack clears and relocks
    @(negedge clk); pdAck = 1'b1;
    @(negedge clk); pdAck = 1'b0;
    chk("R8 ack clears", pdRequest, 1'b0);
    wr(1'b0, 32'h0000_1905);
    chk("R8 relocked", pdRequest, 1'b0);
    // R8 ack and write in same cycle
    openKey();
    wr(1'b0, 32'h0000_1905, 1'b1);
    chk("R8 ack wins", pdRequest, 1'b0);
    wr(1'b0, 32'h0000_1905);
    chk("R8 ack relocks same cycle", pdRequest, 1'b0);
    // R7 wrong key locks until reset
    wr(1'b1, 32'h0000_1234);
    openKey();
    wr(1'b0, 32'h0000_1905);
    chk("R7 dead key", pdRequest, 1'b0);
    doReset();
    rd(1'b0, 32'h0, "R1 reset after use");
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, 32'h0000_490F, "R10 unused zero locked");
    openKey();
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, 32'h0000_590F, "R7 key works after reset");
    chk("R11 latency max", latency, 32'hF);
    repeat (3) @(negedge clk);
    chk("R10 all reads answered", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule